// File: doc/BRIEF.md
# Receive Descriptor Engine

This block is the receive half of a DMA network controller. It works through a list of four-word receive descriptors in system memory over a request/response port, and moves incoming frame bytes into the buffers those descriptors point to. A descriptor is used only while the engine owns it. When the engine has filled one, it writes a status word back and hands the descriptor to the host. If the engine finds a descriptor it does not own, it stops, raises a flag saying no receive buffer is available, and waits for a poll-demand pulse from software.

Frames arrive as a byte stream with valid/ready flow control. Side-band flags for checksum, collision, address-filter, multicast and length/type arrive with the final byte. A frame may span both buffers of a descriptor and several descriptors in turn. The first descriptor of a frame is marked, and so is the last. The last one carries the frame length and the error bits. The list can be laid out as a ring, where a marked descriptor jumps back to the list base, or as a chain, where the second address points to the next descriptor. If the next descriptor is not available when the buffers run out, the rest of the frame is thrown away and the status reports truncation.

Top module: `rxd_engine`

## Requirements
- R1: After reset the engine makes no memory request, holds `rx_ready` and `rx_unavail` low, and waits for `poll_demand`. The first poll loads the current descriptor address from `list_base`.
- R2: A descriptor is fetched as four word reads at offsets 0, 4, 8 and 12 (status, control, buffer-1 address, buffer-2 address). If bit 31 of the status word is clear, the engine suspends. While suspended, `rx_unavail` is high and `rx_ready` is low until the next `poll_demand` pulse restarts the fetch at the same address.
- R3: Received bytes are packed little-endian into 32-bit words, with the first byte in bits 7:0. Words are written at rising word addresses, first into buffer 1 and then into buffer 2. The buffer sizes in bytes are control bits 10:0 and 21:11, and both are multiples of 4. The last word of a frame has its unused byte lanes set to zero.
- R4: When control bit 24 is set, the buffer-2 address is the next descriptor's address and the buffer-2 size is ignored.
- R5: The next descriptor is at `list_base` when control bit 25 is set. Otherwise it is at the buffer-2 address when bit 24 is set. Otherwise it is the current address plus 16. After a write-back the engine fetches the next descriptor without waiting for a poll.
- R6: Each write-back goes to word 0 of the descriptor with bit 31 clear. Bit 9 is set on the descriptor holding the start of a frame, and bit 8 on the one holding its end. A descriptor that is neither last nor truncated has only bit 9 (if it is first) set.
- R7: On the last descriptor, bits 29:16 give the frame length in bytes, CRC included. The field is zero when the frame was truncated.
- R8: If the buffers are full, the frame continues, and the next descriptor's status bit 31 is clear, the engine discards the rest of the frame. It then writes the current descriptor back with bits 8 and 14 set, leaves the next descriptor unwritten, and suspends.
- R9: On the last descriptor the side-band flags are reported, sampled with the final byte: checksum error in bit 1, collision in bit 6, length/type above 1500 in bit 5, multicast in bit 10, filter miss in bit 30. Bit 7 is set for lengths above 1518, and bit 11 for lengths below 64. Bit 15 is the OR of bits 1, 6, 7, 11 and 14.
- R10: A memory request, once raised, keeps its address, direction and data until `mem_req_ready` accepts it. Only one read is outstanding at a time, and writes get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| list_base | input | AW | Byte address of the first descriptor |
| poll_demand | input | 1 | One-cycle pulse asking the engine to look at the current descriptor again |
| rx_unavail | output | 1 | High while suspended on a descriptor the engine does not own |
| rx_valid | input | 1 | Frame byte valid |
| rx_ready | output | 1 | Engine accepts a byte |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_crc_err | input | 1 | Checksum failed (with final byte) |
| rx_collision | input | 1 | Collision seen (with final byte) |
| rx_long_type | input | 1 | Length/type field above 1500 (with final byte) |
| rx_multicast | input | 1 | Multicast destination (with final byte) |
| rx_filter_miss | input | 1 | Address filter rejected the frame (with final byte) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
A buffer word write is requested in the cycle after the byte that completes the word (or ends the frame or the buffer) is accepted. The status write follows the last data write, or, on truncation, the final discarded byte. Suspension shows on `rx_unavail` the cycle after a status response with bit 31 clear, and the flag drops the cycle after a poll. Because each write can stall for any number of cycles on `mem_req_ready`, the bench does not count cycles for writes. Its memory model compares every accepted write, address and data, against the next entry of an expected-write queue filled when each frame is sent. Flag checks are sampled on the falling edge once the awaited condition has settled.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int WORD_W      = 32;
  localparam int LEN_W       = 14;
  localparam int SIZE_W      = 11;
  localparam int DESC_BYTES  = 16;

  // status word bit positions (decoded by host software)
  localparam int ST_OWN      = 31;
  localparam int ST_FILT     = 30;
  localparam int ST_LEN_LO   = 16;
  localparam int ST_ERRSUM   = 15;
  localparam int ST_DESCERR  = 14;
  localparam int ST_RUNT     = 11;
  localparam int ST_MCAST    = 10;
  localparam int ST_FIRST    = 9;
  localparam int ST_LAST     = 8;
  localparam int ST_TOOLONG  = 7;
  localparam int ST_COLL     = 6;
  localparam int ST_LTYPE    = 5;
  localparam int ST_CRC      = 1;

  // control word bit positions
  localparam int CT_CHAIN    = 24;
  localparam int CT_RINGEND  = 25;

  typedef enum logic [3:0] {
    S_IDLE, S_SUSP, S_FETCH, S_FILL, S_WRD, S_BUFEND, S_PEEK, S_DROP, S_WB
  } rxd_state_t;

  typedef struct packed {
    logic crc;
    logic coll;
    logic ltype;
    logic mcast;
    logic filt;
  } rxd_flags_t;

endpackage

// File: rtl/rxd_byte_pack.sv
module rxd_byte_pack #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic [7:0]           din,
  output logic [8*LANES-1:0]   word,
  output logic                 at_last_lane
);
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | push;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_last_lane = (cnt_q == CW'(LANES - 1));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_en;
    assign lane_en = clr | (push && (cnt_q == CW'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= clr ? 8'h00 : din;
    end
    assign word[8*g +: 8] = lane_q;
  end

endmodule

// File: rtl/rxd_next_addr.sv
module rxd_next_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] addr2,
  input  logic          chained,
  input  logic          ring_end,
  output logic [AW-1:0] next_addr
);
  import rxd_pkg::*;

  always_comb begin
    if (ring_end)     next_addr = base_addr;
    else if (chained) next_addr = addr2;
    else              next_addr = cur_addr + AW'(DESC_BYTES);
  end

endmodule

// File: rtl/rxd_status_word.sv
module rxd_status_word #(
  parameter int MAX_LEN = 1518,
  parameter int MIN_LEN = 64
) (
  input  logic                      first,
  input  logic                      last,
  input  logic                      trunc,
  input  logic [rxd_pkg::LEN_W-1:0] len,
  input  rxd_pkg::rxd_flags_t       flags,
  output logic [rxd_pkg::WORD_W-1:0] status
);
  import rxd_pkg::*;

  logic de, tl, runt;

  always_comb begin
    de   = last & trunc;
    tl   = last && (len > LEN_W'(MAX_LEN));
    runt = last && (len < LEN_W'(MIN_LEN));
    status = '0;
    status[ST_FIRST] = first;
    status[ST_LAST]  = last;
    if (last) begin
      status[ST_FILT]                       = flags.filt;
      status[ST_LEN_LO +: LEN_W]            = de ? '0 : len;
      status[ST_DESCERR]                    = de;
      status[ST_RUNT]                       = runt;
      status[ST_MCAST]                      = flags.mcast;
      status[ST_TOOLONG]                    = tl;
      status[ST_COLL]                       = flags.coll;
      status[ST_LTYPE]                      = flags.ltype;
      status[ST_CRC]                        = flags.crc;
      status[ST_ERRSUM] = flags.crc | flags.coll | tl | runt | de;
    end
  end

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine #(
  parameter int AW      = 32,
  parameter int MAX_LEN = 1518,
  parameter int MIN_LEN = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] list_base,
  input  logic          poll_demand,
  output logic          rx_unavail,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_err,
  input  logic          rx_collision,
  input  logic          rx_long_type,
  input  logic          rx_multicast,
  input  logic          rx_filter_miss,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_rdata
);
  import rxd_pkg::*;

  localparam int LANES = WORD_W / 8;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  // state
  rxd_state_t        st_q, st_d;
  logic [1:0]        idx_q, idx_d;
  logic              wait_q, wait_d;
  logic [AW-1:0]     cur_q, cur_d;
  logic [SIZE_W-1:0] b1_q, b1_d, b2_q, b2_d;
  logic              chain_q, chain_d, ring_q, ring_d;
  logic [AW-1:0]     a1_q, a1_d, a2_q, a2_d;
  logic [AW-1:0]     bufa_q, bufa_d;
  logic [SIZE_W-1:0] left_q, left_d;
  logic              inb2_q, inb2_d;
  logic              fd_q, fd_d;
  logic              mid_q, mid_d;
  logic              trunc_q, trunc_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              lastb_q, lastb_d;
  logic              final_q, final_d;
  rxd_flags_t        flg_q, flg_d;

  logic              pk_clr, pk_push, pk_at_last;
  logic [WORD_W-1:0] pk_word;
  logic [AW-1:0]     nxt_addr;
  logic [WORD_W-1:0] status_w;
  rxd_flags_t        flg_in;
  logic [LEN_W-1:0]  len_inc;

  rxd_byte_pack #(.LANES(LANES)) u_pack (
    .clk(clk), .rst_n(rst_q), .clr(pk_clr), .push(pk_push),
    .din(rx_data), .word(pk_word), .at_last_lane(pk_at_last)
  );

  rxd_next_addr #(.AW(AW)) u_next (
    .cur_addr(cur_q), .base_addr(list_base), .addr2(a2_q),
    .chained(chain_q), .ring_end(ring_q), .next_addr(nxt_addr)
  );

  rxd_status_word #(.MAX_LEN(MAX_LEN), .MIN_LEN(MIN_LEN)) u_status (
    .first(fd_q), .last(final_q), .trunc(trunc_q), .len(len_q),
    .flags(flg_q), .status(status_w)
  );

  always_comb begin
    flg_in.crc   = rx_crc_err;
    flg_in.coll  = rx_collision;
    flg_in.ltype = rx_long_type;
    flg_in.mcast = rx_multicast;
    flg_in.filt  = rx_filter_miss;
    len_inc = (len_q == {LEN_W{1'b1}}) ? len_q : len_q + 1'b1;
  end

  // next-state logic
  always_comb begin
    st_d = st_q;  idx_d = idx_q;  wait_d = wait_q;  cur_d = cur_q;
    b1_d = b1_q;  b2_d = b2_q;    chain_d = chain_q; ring_d = ring_q;
    a1_d = a1_q;  a2_d = a2_q;    bufa_d = bufa_q;   left_d = left_q;
    inb2_d = inb2_q; fd_d = fd_q; mid_d = mid_q;     trunc_d = trunc_q;
    len_d = len_q; lastb_d = lastb_q; final_d = final_q; flg_d = flg_q;
    pk_clr = 1'b0; pk_push = 1'b0;
    mem_req_valid = 1'b0; mem_req_write = 1'b0;
    mem_req_addr = cur_q; mem_req_wdata = '0;
    rx_ready = 1'b0;

    unique case (st_q)
      S_IDLE, S_SUSP: begin
        if (poll_demand) begin
          st_d = S_FETCH; idx_d = 2'd0; wait_d = 1'b0;
          if (st_q == S_IDLE) cur_d = list_base;
        end
      end

      S_FETCH: begin
        mem_req_addr = cur_q + {{(AW-4){1'b0}}, idx_q, 2'b00};
        if (!wait_q) begin
          mem_req_valid = 1'b1;
          if (mem_req_ready) wait_d = 1'b1;
        end else if (mem_rsp_valid) begin
          wait_d = 1'b0;
          idx_d  = idx_q + 1'b1;
          unique case (idx_q)
            2'd0: if (!mem_rsp_rdata[ST_OWN]) st_d = S_SUSP;
            2'd1: begin
              b1_d    = mem_rsp_rdata[SIZE_W-1:0];
              b2_d    = mem_rsp_rdata[2*SIZE_W-1:SIZE_W];
              chain_d = mem_rsp_rdata[CT_CHAIN];
              ring_d  = mem_rsp_rdata[CT_RINGEND];
            end
            2'd2: a1_d = mem_rsp_rdata[AW-1:0];
            default: begin
              a2_d   = mem_rsp_rdata[AW-1:0];
              bufa_d = a1_q;
              left_d = b1_q;
              inb2_d = 1'b0;
              fd_d   = ~mid_q;
              st_d   = S_FILL;
            end
          endcase
        end
      end

      S_FILL: begin
        if (left_q == '0) begin
          st_d = S_BUFEND;
        end else begin
          rx_ready = 1'b1;
          if (rx_valid) begin
            pk_push = 1'b1;
            len_d   = len_inc;
            left_d  = left_q - 1'b1;
            if (rx_last) begin
              lastb_d = 1'b1;
              flg_d   = flg_in;
            end
            if (pk_at_last || rx_last || (left_q == SIZE_W'(1))) st_d = S_WRD;
          end
        end
      end

      S_WRD: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = bufa_q;
        mem_req_wdata = pk_word;
        if (mem_req_ready) begin
          pk_clr = 1'b1;
          bufa_d = bufa_q + AW'(LANES);
          if (lastb_q) begin
            final_d = 1'b1;
            st_d    = S_WB;
          end else begin
            st_d = S_FILL;
          end
        end
      end

      S_BUFEND: begin
        if (!inb2_q && !chain_q && (b2_q != '0)) begin
          bufa_d = a2_q;
          left_d = b2_q;
          inb2_d = 1'b1;
          st_d   = S_FILL;
        end else begin
          wait_d = 1'b0;
          st_d   = S_PEEK;
        end
      end

      S_PEEK: begin
        mem_req_addr = nxt_addr;
        if (!wait_q) begin
          mem_req_valid = 1'b1;
          if (mem_req_ready) wait_d = 1'b1;
        end else if (mem_rsp_valid) begin
          wait_d = 1'b0;
          if (mem_rsp_rdata[ST_OWN]) begin
            final_d = 1'b0;
            st_d    = S_WB;
          end else begin
            trunc_d = 1'b1;
            st_d    = S_DROP;
          end
        end
      end

      S_DROP: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          len_d = len_inc;
          if (rx_last) begin
            lastb_d = 1'b1;
            flg_d   = flg_in;
            final_d = 1'b1;
            st_d    = S_WB;
          end
        end
      end

      S_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = cur_q;
        mem_req_wdata = status_w;
        if (mem_req_ready) begin
          cur_d  = nxt_addr;
          idx_d  = 2'd0;
          wait_d = 1'b0;
          st_d   = S_FETCH;
          if (final_q) begin
            mid_d = 1'b0; trunc_d = 1'b0; len_d = '0; lastb_d = 1'b0;
          end else begin
            mid_d = 1'b1;
          end
        end
      end

      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q <= S_IDLE; idx_q <= '0; wait_q <= 1'b0; cur_q <= '0;
      b1_q <= '0; b2_q <= '0; chain_q <= 1'b0; ring_q <= 1'b0;
      a1_q <= '0; a2_q <= '0; bufa_q <= '0; left_q <= '0;
      inb2_q <= 1'b0; fd_q <= 1'b0; mid_q <= 1'b0; trunc_q <= 1'b0;
      len_q <= '0; lastb_q <= 1'b0; final_q <= 1'b0; flg_q <= '0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; wait_q <= wait_d; cur_q <= cur_d;
      b1_q <= b1_d; b2_q <= b2_d; chain_q <= chain_d; ring_q <= ring_d;
      a1_q <= a1_d; a2_q <= a2_d; bufa_q <= bufa_d; left_q <= left_d;
      inb2_q <= inb2_d; fd_q <= fd_d; mid_q <= mid_d; trunc_q <= trunc_d;
      len_q <= len_d; lastb_q <= lastb_d; final_q <= final_d; flg_q <= flg_d;
    end
  end

  assign rx_unavail = (st_q == S_SUSP);

  // assertions
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata))); // R10

  AST_SUSP_AFTER_UNOWNED: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rx_unavail) |-> ($past(mem_rsp_valid) && !$past(mem_rsp_rdata[ST_OWN]))); // R2

  AST_WB_RELEASES_OWN: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req_valid && mem_req_write && (mem_req_addr == cur_q) && (st_q == S_WB))
      |-> !mem_req_wdata[ST_OWN]); // R6

  AST_DESCERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == S_WB && mem_req_valid && mem_req_wdata[ST_DESCERR])
      |-> (mem_req_wdata[ST_ERRSUM] && mem_req_wdata[ST_LAST])); // R9

  AST_TRUNC_NO_LEN: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == S_WB && mem_req_valid && mem_req_wdata[ST_DESCERR])
      |-> (mem_req_wdata[ST_LEN_LO +: LEN_W] == '0)); // R7

  AST_NO_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    (st_q == S_FETCH || st_q == S_WB || st_q == S_PEEK) |-> !rx_ready); // R1

endmodule

// File: tb/rxd_engine_bench.sv
module rxd_engine_bench;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] list_base;
  logic          poll_demand;
  logic          rx_unavail;
  logic          rx_valid, rx_ready, rx_last;
  logic [7:0]    rx_data;
  logic          rx_crc_err, rx_collision, rx_long_type, rx_multicast, rx_filter_miss;
  logic          mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [31:0]   mem_req_wdata;
  logic          mem_rsp_valid;
  logic [31:0]   mem_rsp_rdata;

  always #10 clk = ~clk;

  rxd_engine #(.AW(AW)) u_rxd_engine (
    .clk(clk), .rst_n(rst_n), .list_base(list_base), .poll_demand(poll_demand),
    .rx_unavail(rx_unavail), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .rx_crc_err(rx_crc_err),
    .rx_collision(rx_collision), .rx_long_type(rx_long_type),
    .rx_multicast(rx_multicast), .rx_filter_miss(rx_filter_miss),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct { logic [31:0] addr; logic [31:0] data; string tag; } exp_t;
  exp_t exp_q[$];

  logic [31:0] mem [0:1023];
  int unsigned cyc = 0;
  logic        stall_q = 1'b0;
  logic [31:0] stall_addr;

  assign mem_req_ready = (cyc % 3) != 2;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model and write monitor (scoreboard consumer)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (rst_n) begin
      if (stall_q)
        chk(mem_req_valid && mem_req_addr == stall_addr, "R10 request held", mem_req_addr, stall_addr);
      stall_q    <= mem_req_valid && !mem_req_ready;
      stall_addr <= mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr[11:2]] = mem_req_wdata;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3 unexpected write", mem_req_addr, 32'h0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(mem_req_addr == e.addr, {e.tag, " addr"}, mem_req_addr, e.addr);
            chk(mem_req_wdata == e.data, {e.tag, " data"}, mem_req_wdata, e.data);
          end
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem[mem_req_addr[11:2]];
        end
      end
    end
  end

  function automatic logic [7:0] fbyte(input int seed, input int i);
    return 8'((seed + i) & 8'hFF);
  endfunction

  // driver-side producers of expected items
  task automatic exp_words(input logic [31:0] addr, input int seed, input int first, input int n, input string tag);
    for (int w = 0; w < (n + 3) / 4; w++) begin
      exp_t e;
      e.addr = addr + 32'(4 * w);
      e.data = '0;
      for (int b = 0; b < 4; b++)
        if (4 * w + b < n) e.data[8*b +: 8] = fbyte(seed, first + 4 * w + b);
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic exp_status(input logic [31:0] addr, input logic [31:0] data, input string tag);
    exp_t e;
    e.addr = addr; e.data = data; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic send_frame(input int n, input int seed, input bit crc, input bit coll,
                            input bit lt, input bit mc, input bit ff);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbyte(seed, i);
      rx_last  = (i == n - 1);
      rx_crc_err = crc; rx_collision = coll; rx_long_type = lt;
      rx_multicast = mc; rx_filter_miss = ff;
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    rx_crc_err = 0; rx_collision = 0; rx_long_type = 0; rx_multicast = 0; rx_filter_miss = 0;
  endtask

  task automatic pulse_poll();
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
  endtask

  task automatic wait_settled();
    @(negedge clk);
    while (!(rx_unavail && exp_q.size() == 0)) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired, pending=%0d expected=0", exp_q.size());
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    rst_n = 1'b0; list_base = 32'h0; poll_demand = 1'b0;
    rx_valid = 0; rx_last = 0; rx_data = 0;
    rx_crc_err = 0; rx_collision = 0; rx_long_type = 0; rx_multicast = 0; rx_filter_miss = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req_valid, "R1 no request after reset", 32'(mem_req_valid), 0);
    chk(!rx_ready,      "R1 rx_ready low after reset", 32'(rx_ready), 0);
    chk(!rx_unavail,    "R1 rx_unavail low after reset", 32'(rx_unavail), 0);

    // ring: D0 two buffers, D1 chained to D2, D2 marks ring end
    mem[0]  = 32'h8000_0000; mem[1]  = (32'd8 << 11) | 32'd8;  mem[2]  = 32'h100; mem[3]  = 32'h140;
    mem[4]  = 32'h8000_0000; mem[5]  = (32'd1 << 24) | (32'd8 << 11) | 32'd4; mem[6] = 32'h180; mem[7] = 32'h20;
    mem[8]  = 32'h8000_0000; mem[9]  = (32'd1 << 25) | 32'd16; mem[10] = 32'h1C0; mem[11] = 32'h0;

    exp_words(32'h100, 16, 0, 8, "R3 frame A buffer 1");
    exp_words(32'h140, 16, 8, 2, "R3 frame A buffer 2 partial");
    exp_status(32'h00, 32'h000A_8B02, "R9 frame A status");
    exp_words(32'h180, 64, 0, 4, "R4 frame B chained buffer");
    exp_status(32'h10, 32'h0000_0200, "R6 frame B first-only status");
    exp_words(32'h1C0, 64, 4, 2, "R4 frame B next via chain");
    exp_status(32'h20, 32'h0006_8900, "R7 frame B last status");

    pulse_poll();
    send_frame(10, 16, 1, 0, 0, 0, 0);
    send_frame(6, 64, 0, 0, 0, 0, 0);
    wait_settled();
    chk(rx_unavail, "R5 wrap to base finds released descriptor", 32'(rx_unavail), 1);

    // suspended engine must refuse bytes
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hEE; rx_last = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!rx_ready, "R2 rx_ready low while suspended", 32'(rx_ready), 0);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
    chk(exp_q.size() == 0 && mem[0] == 32'h000A_8B02, "R2 no write while suspended", mem[0], 32'h000A_8B02);

    // long frame in a re-armed D0
    mem[0] = 32'h8000_0000; mem[1] = 32'd2044; mem[2] = 32'h400; mem[3] = 32'h0;
    exp_words(32'h400, 3, 0, 1520, "R3 frame C data");
    exp_status(32'h00, 32'h45F0_87A0, "R9 frame C long status");
    pulse_poll();
    chk(!rx_unavail, "R2 poll clears rx_unavail", 32'(rx_unavail), 0);
    send_frame(1520, 3, 0, 0, 1, 1, 1);
    wait_settled();

    // truncation: D1 re-armed, D2 still released
    mem[4] = 32'h8000_0000;
    exp_words(32'h180, 200, 0, 4, "R8 frame D fits first buffer");
    exp_status(32'h10, 32'h0000_CB40, "R8 frame D truncated status");
    pulse_poll();
    send_frame(9, 200, 0, 1, 0, 0, 0);
    wait_settled();
    chk(mem[8] == 32'h0006_8900, "R8 unowned next descriptor untouched", mem[8], 32'h0006_8900);
    chk(exp_q.size() == 0, "R6 all expected writes seen", 32'(exp_q.size()), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule